// File: doc/BRIEF.md
# Gain Fade-In Ramp Controller

This block owns the gain code of an input programmable-gain amplifier while that gain is brought up smoothly from a low setting, usually the mute code. Software writes a starting gain while the block is idle, picks a step size, an update period and a target level, and then sets the fade-in enable after having cleared it. The rising edge of that enable starts the ramp.

While ramping, a timer counts sample strobes. Each time the selected period expires, one gain step is armed. The armed step is applied at the next zero crossing of the input signal, so the gain never jumps in the middle of a waveform. The ramp ends in one of three ways. The gain may reach the target level, where it saturates without overshoot. The limiter flag may fire, which hands control to the level-control loop. Or software may abort it by dropping the enable or by setting the fade-out enable. A one-cycle pulse on one of two outputs reports which of the first two endings occurred.

Top module: `fade_ramp_top`

## Requirements
- R1: After reset, gainCode is 0 and rampActive, doneRef and doneLimit are all 0.
- R2: A ramp starts only when fadeInEn goes from 0 to 1 while fadeOutEn is 0. rampActive is 1 after the next clock edge. Holding fadeInEn at 1 after a ramp has ended never starts another ramp.
- R3: Each applied step raises gainCode by 1 << stepSel, so codes 0, 1, 2 and 3 give steps of 1, 2, 4 and 8.
- R4: periodSel codes 0 to 3 select periods of PERIOD0 to PERIOD3 sample strobes (defaults 4, 8, 16 and 32). With a strobe and a zero crossing on every cycle, step k is applied at clock edge k*P+1 after the edge that starts the ramp.
- R5: A period that expires without a zero crossing arms a step that is held. The next cycle with zeroCross high applies exactly one step, however many periods have expired in the meantime.
- R6: gainCode never passes refLevel. The step that reaches or would pass refLevel sets gainCode to refLevel, ends the ramp, and raises doneRef for exactly one cycle.
- R7: limitHit during a ramp ends it on the next edge. doneLimit is high for exactly one cycle and gainCode stays at its present value.
- R8: fadeOutEn takes priority. While it is 1, a rising fadeInEn starts no ramp. Setting it during a ramp ends the ramp with no done pulse.
- R9: Clearing fadeInEn during a ramp ends the ramp with gainCode frozen and no done pulse.
- R10: gainWrEn loads gainWrData into gainCode only while no ramp is active. During a ramp the write is ignored.
- R11: A start with gainCode already at or above refLevel starts no ramp. It gives a doneRef pulse on the next edge and leaves gainCode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fadeInEn | input | 1 | Fade-in enable; its rising edge starts a ramp |
| fadeOutEn | input | 1 | Fade-out enable; overrides fade-in |
| stepSel | input | 2 | Step size code (step = 1 << stepSel) |
| periodSel | input | 2 | Update period code |
| refLevel | input | GAIN_W | Target gain code |
| gainWrEn | input | 1 | Software write of the gain code |
| gainWrData | input | GAIN_W | Gain value to write |
| sampleStb | input | 1 | One pulse per audio sample |
| zeroCross | input | 1 | Input signal crossed zero in this cycle |
| limitHit | input | 1 | Limiter detection flag |
| gainCode | output | GAIN_W | Gain code sent to the amplifier |
| rampActive | output | 1 | Ramp in progress |
| doneRef | output | 1 | One-cycle pulse: ramp ended at refLevel |
| doneLimit | output | 1 | One-cycle pulse: ramp ended on limiter |

## Verification
The assertions assume that refLevel and stepSel stay constant while a ramp runs. Under that assumption, every gain change during a ramp is an increase of no more than one step that stays at or below refLevel. The stimulus changes these fields, and loads gains, only while rampActive is low. The limiter and fade-out inputs are raised only while a ramp is active, or while the test is checking that no ramp starts.

// File: rtl/fade_ramp_pkg.sv
package fade_ramp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGain;   // copy software value into the gain register
    logic takeStep;   // apply one (saturating) step
    logic runTimer;   // period timer counts strobes; cleared otherwise
  } dpCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } rampState_t;

endpackage

// File: rtl/fade_ramp_dp.sv
module fade_ramp_dp
  import fade_ramp_pkg::*;
#(
  parameter int GAIN_W  = 7,
  parameter int SEL_W   = 2,
  parameter int PERIOD0 = 4,
  parameter int PERIOD1 = 8,
  parameter int PERIOD2 = 16,
  parameter int PERIOD3 = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [SEL_W-1:0]  stepSel,
  input  logic [1:0]        periodSel,
  input  logic [GAIN_W-1:0] refLevel,
  input  logic [GAIN_W-1:0] gainWrData,
  input  logic              sampleStb,
  output logic [GAIN_W-1:0] gainCode,
  output logic              periodTick,
  output logic              stepHitsRef,
  output logic              atOrAboveRef
);

  function automatic int maxOf4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  localparam int PER_MAX = maxOf4(PERIOD0, PERIOD1, PERIOD2, PERIOD3);
  localparam int CNT_W   = (PER_MAX > 1) ? $clog2(PER_MAX) : 1;
  localparam int SUM_W   = GAIN_W + 1;

  logic [CNT_W-1:0] strobeCnt;
  logic [CNT_W-1:0] perLimit;
  logic [SUM_W-1:0] stepAmt;
  logic [SUM_W-1:0] stepSum;
  logic [GAIN_W-1:0] nextGain;

  // Period code to terminal count
  always_comb begin
    case (periodSel)
      2'd0:    perLimit = CNT_W'(PERIOD0 - 1);
      2'd1:    perLimit = CNT_W'(PERIOD1 - 1);
      2'd2:    perLimit = CNT_W'(PERIOD2 - 1);
      default: perLimit = CNT_W'(PERIOD3 - 1);
    endcase
  end

  assign periodTick = cmd.runTimer && sampleStb && (strobeCnt == perLimit);

  always_ff @(posedge clk) begin
    if (!rstN || !cmd.runTimer) begin
      strobeCnt <= '0;
    end else if (sampleStb) begin
      if (strobeCnt == perLimit) strobeCnt <= '0;
      else                       strobeCnt <= strobeCnt + 1'b1;
    end
  end

  // Saturating step toward the reference
  assign stepAmt      = SUM_W'(1) << stepSel;
  assign stepSum      = {1'b0, gainCode} + stepAmt;
  assign stepHitsRef  = stepSum >= {1'b0, refLevel};
  assign atOrAboveRef = gainCode >= refLevel;
  assign nextGain     = stepHitsRef ? refLevel : stepSum[GAIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)             gainCode <= '0;
    else if (cmd.loadGain) gainCode <= gainWrData;
    else if (cmd.takeStep) gainCode <= nextGain;
  end

endmodule

// File: rtl/fade_ramp_ctrl.sv
module fade_ramp_ctrl
  import fade_ramp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   fadeInEn,
  input  logic   fadeOutEn,
  input  logic   gainWrEn,
  input  logic   zeroCross,
  input  logic   limitHit,
  input  logic   periodTick,
  input  logic   stepHitsRef,
  input  logic   atOrAboveRef,
  output dpCmd_t cmd,
  output logic   rampActive,
  output logic   doneRef,
  output logic   doneLimit
);

  rampState_t state, nextState;
  logic prevEn;
  logic stepArmed;
  logic startEdge;
  logic setRef, setLim;
  logic stayRamp;

  assign startEdge = fadeInEn && !prevEn && !fadeOutEn;

  always_comb begin
    nextState = state;
    cmd       = '0;
    setRef    = 1'b0;
    setLim    = 1'b0;
    case (state)
      ST_IDLE: begin
        cmd.loadGain = gainWrEn;
        if (startEdge) begin
          if (atOrAboveRef) setRef    = 1'b1;
          else              nextState = ST_RAMP;
        end
      end
      ST_RAMP: begin
        cmd.runTimer = 1'b1;
        if (!fadeInEn || fadeOutEn) begin
          nextState = ST_IDLE;
        end else if (limitHit) begin
          nextState = ST_IDLE;
          setLim    = 1'b1;
        end else if (stepArmed && zeroCross) begin
          cmd.takeStep = 1'b1;
          if (stepHitsRef) begin
            nextState = ST_IDLE;
            setRef    = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign stayRamp = (state == ST_RAMP) && (nextState == ST_RAMP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      prevEn    <= 1'b0;
      stepArmed <= 1'b0;
      doneRef   <= 1'b0;
      doneLimit <= 1'b0;
    end else begin
      state     <= nextState;
      prevEn    <= fadeInEn;
      doneRef   <= setRef;
      doneLimit <= setLim;
      if (!stayRamp) stepArmed <= 1'b0;
      else           stepArmed <= (stepArmed && !cmd.takeStep) || periodTick;
    end
  end

  assign rampActive = (state == ST_RAMP);

endmodule

// File: rtl/fade_ramp_top.sv
module fade_ramp_top
  import fade_ramp_pkg::*;
#(
  parameter int GAIN_W  = 7,
  parameter int PERIOD0 = 4,
  parameter int PERIOD1 = 8,
  parameter int PERIOD2 = 16,
  parameter int PERIOD3 = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fadeInEn,
  input  logic              fadeOutEn,
  input  logic [1:0]        stepSel,
  input  logic [1:0]        periodSel,
  input  logic [GAIN_W-1:0] refLevel,
  input  logic              gainWrEn,
  input  logic [GAIN_W-1:0] gainWrData,
  input  logic              sampleStb,
  input  logic              zeroCross,
  input  logic              limitHit,
  output logic [GAIN_W-1:0] gainCode,
  output logic              rampActive,
  output logic              doneRef,
  output logic              doneLimit
);

  dpCmd_t cmd;
  logic   periodTick, stepHitsRef, atOrAboveRef;

  fade_ramp_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fadeInEn     (fadeInEn),
    .fadeOutEn    (fadeOutEn),
    .gainWrEn     (gainWrEn),
    .zeroCross    (zeroCross),
    .limitHit     (limitHit),
    .periodTick   (periodTick),
    .stepHitsRef  (stepHitsRef),
    .atOrAboveRef (atOrAboveRef),
    .cmd          (cmd),
    .rampActive   (rampActive),
    .doneRef      (doneRef),
    .doneLimit    (doneLimit)
  );

  fade_ramp_dp #(
    .GAIN_W  (GAIN_W),
    .SEL_W   (2),
    .PERIOD0 (PERIOD0),
    .PERIOD1 (PERIOD1),
    .PERIOD2 (PERIOD2),
    .PERIOD3 (PERIOD3)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .stepSel      (stepSel),
    .periodSel    (periodSel),
    .refLevel     (refLevel),
    .gainWrData   (gainWrData),
    .sampleStb    (sampleStb),
    .gainCode     (gainCode),
    .periodTick   (periodTick),
    .stepHitsRef  (stepHitsRef),
    .atOrAboveRef (atOrAboveRef)
  );

endmodule

// File: rtl/fade_ramp_chk.sv
module fade_ramp_chk #(
  parameter int GAIN_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              fadeInEn,
  input logic              fadeOutEn,
  input logic [1:0]        stepSel,
  input logic [GAIN_W-1:0] refLevel,
  input logic              limitHit,
  input logic [GAIN_W-1:0] gainCode,
  input logic              rampActive,
  input logic              doneRef,
  input logic              doneLimit
);

  logic [GAIN_W:0] stepSize;
  assign stepSize = (GAIN_W+1)'(1) << stepSel;

  // R6: ramp never carries the gain past the reference
  a_r6_no_overshoot: assert property (@(posedge clk) disable iff (!rstN)
    $past(rampActive) |-> gainCode <= refLevel);

  // R3: a change during a ramp is a rise of at most one step
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rampActive) && gainCode != $past(gainCode)) |->
      (gainCode > $past(gainCode)) &&
      ({1'b0, gainCode} - {1'b0, $past(gainCode)} <= stepSize));

  // R7: limiter ends the ramp with a limit pulse
  a_r7_limit_ends: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && limitHit && fadeInEn && !fadeOutEn) |=>
      (!rampActive && doneLimit && !doneRef));

  // R8: fade-out leaves no ramp running
  a_r8_fadeout_wins: assert property (@(posedge clk) disable iff (!rstN)
    fadeOutEn |=> !rampActive);

  // R9: dropped enable ends the ramp
  a_r9_abort: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && !fadeInEn) |=> (!rampActive && !doneRef && !doneLimit));

  // R6/R7: done pulses last one cycle and never coincide
  a_r6_ref_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneRef |=> !doneRef);
  a_r7_lim_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneLimit |=> !doneLimit);
  a_r6_causes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneRef && doneLimit));

  // R7: gain frozen on a limiter ending
  a_r7_gain_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneLimit) |-> $stable(gainCode));

endmodule

bind fade_ramp_top fade_ramp_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fadeInEn   (fadeInEn),
  .fadeOutEn  (fadeOutEn),
  .stepSel    (stepSel),
  .refLevel   (refLevel),
  .limitHit   (limitHit),
  .gainCode   (gainCode),
  .rampActive (rampActive),
  .doneRef    (doneRef),
  .doneLimit  (doneLimit)
);

// File: tb/tb_fade_ramp_top.sv
module tb_fade_ramp_top;

  localparam int CLK_PERIOD = 10;
  localparam int GW = 7;

  typedef struct packed {
    logic [1:0]    stepSel;
    logic [1:0]    periodSel;
    logic [GW-1:0] startGain;
    logic [GW-1:0] refLvl;
    logic [GW-1:0] expSteps;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 7'd0,  7'd5,  7'd5},
    '{2'd1, 2'd1, 7'd0,  7'd7,  7'd4},
    '{2'd3, 2'd0, 7'd10, 7'd40, 7'd4},
    '{2'd2, 2'd2, 7'd0,  7'd96, 7'd24},
    '{2'd0, 2'd3, 7'd90, 7'd93, 7'd3}
  };

  logic clk = 1'b0;
  logic rstN;
  logic fadeInEn, fadeOutEn, gainWrEn, sampleStb, zeroCross, limitHit;
  logic [1:0] stepSel, periodSel;
  logic [GW-1:0] refLevel, gainWrData, gainCode;
  logic rampActive, doneRef, doneLimit;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fade_ramp_top dut (
    .clk(clk), .rstN(rstN), .fadeInEn(fadeInEn), .fadeOutEn(fadeOutEn),
    .stepSel(stepSel), .periodSel(periodSel), .refLevel(refLevel),
    .gainWrEn(gainWrEn), .gainWrData(gainWrData), .sampleStb(sampleStb),
    .zeroCross(zeroCross), .limitHit(limitHit), .gainCode(gainCode),
    .rampActive(rampActive), .doneRef(doneRef), .doneLimit(doneLimit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  task automatic loadGain(input logic [GW-1:0] g);
    gainWrEn = 1'b1; gainWrData = g;
    cyc();
    gainWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        summary();
      end
    end
  end

  initial begin
    logic [GW-1:0] held;
    int steps;
    logic [GW-1:0] last;
    rstN = 1'b0; fadeInEn = 0; fadeOutEn = 0; gainWrEn = 0; gainWrData = '0;
    sampleStb = 0; zeroCross = 0; limitHit = 0; stepSel = 0; periodSel = 0;
    refLevel = '0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1 reset state
    check(gainCode == 0, "R1 gain", gainCode, 0);
    check(!rampActive && !doneRef && !doneLimit, "R1 status",
          {rampActive, doneRef, doneLimit}, 0);

    // Vector table: full ramps (R3, R4, R6, R10)
    sampleStb = 1; zeroCross = 1;
    for (int v = 0; v < NVEC; v++) begin
      fadeInEn = 0;
      stepSel = VECS[v].stepSel; periodSel = VECS[v].periodSel;
      refLevel = VECS[v].refLvl;
      loadGain(VECS[v].startGain);
      check(gainCode == VECS[v].startGain, "R10 idle load", gainCode, VECS[v].startGain);
      fadeInEn = 1;
      steps = 0; last = gainCode;
      for (int c = 0; c < 4000; c++) begin
        cyc();
        if (gainCode != last) begin
          steps++;
          if (gainCode != VECS[v].refLvl)
            check(int'(gainCode) - int'(last) == (1 << VECS[v].stepSel), "R3 step size",
                  int'(gainCode) - int'(last), 1 << VECS[v].stepSel);
          last = gainCode;
        end
        if (doneRef) break;
      end
      check(doneRef == 1, "R6 done pulse", doneRef, 1);
      check(gainCode == VECS[v].refLvl, "R6 saturate at ref", gainCode, VECS[v].refLvl);
      check(steps == int'(VECS[v].expSteps), "R3 step count", steps, VECS[v].expSteps);
      check(!rampActive, "R6 ramp ended", rampActive, 0);
      cyc();
      check(!doneRef, "R6 one-cycle pulse", doneRef, 0);
    end

    // R4 step timing with period 4
    fadeInEn = 0; stepSel = 0; periodSel = 0; refLevel = 7'd50;
    loadGain(7'd0);
    fadeInEn = 1;
    cyc();
    check(rampActive, "R2 active after edge", rampActive, 1);
    for (int i = 0; i < 4; i++) cyc();
    check(gainCode == 0, "R4 no step at edge P", gainCode, 0);
    cyc();
    check(gainCode == 1, "R4 step at edge P+1", gainCode, 1);

    // R5 zero-cross gating
    zeroCross = 0;
    repeat (12) cyc();
    check(gainCode == 1, "R5 held without zero cross", gainCode, 1);
    zeroCross = 1;
    cyc();
    zeroCross = 0;
    check(gainCode == 2, "R5 one step on zero cross", gainCode, 2);
    repeat (2) cyc();
    check(gainCode == 2, "R5 single step only", gainCode, 2);

    // R10 write ignored during ramp
    gainWrEn = 1; gainWrData = 7'd100;
    cyc();
    gainWrEn = 0;
    check(gainCode == 2, "R10 write ignored in ramp", gainCode, 2);

    // R7 limiter
    limitHit = 1;
    cyc();
    limitHit = 0;
    check(doneLimit && !rampActive && !doneRef, "R7 limit end",
          {doneLimit, rampActive, doneRef}, 4);
    check(gainCode == 2, "R7 gain frozen", gainCode, 2);
    cyc();
    check(!doneLimit, "R7 one-cycle pulse", doneLimit, 0);

    // R2 level held: no restart
    zeroCross = 1;
    repeat (10) cyc();
    check(!rampActive && gainCode == 2, "R2 level no restart", gainCode, 2);

    // R9 abort by clearing enable
    fadeInEn = 0; cyc();
    fadeInEn = 1; cyc();
    check(rampActive, "R9 restarted", rampActive, 1);
    repeat (6) cyc();
    held = gainCode;
    fadeInEn = 0;
    cyc();
    check(!rampActive && !doneRef && !doneLimit, "R9 abort status",
          {rampActive, doneRef, doneLimit}, 0);
    check(gainCode == held, "R9 gain frozen", gainCode, held);
    repeat (8) cyc();
    check(gainCode == held, "R9 gain stays", gainCode, held);

    // R8 fade-out priority at start
    fadeOutEn = 1; fadeInEn = 1;
    repeat (10) cyc();
    check(!rampActive && gainCode == held, "R8 no start under fade-out", gainCode, held);
    // R8 fade-out mid-ramp
    fadeOutEn = 0; fadeInEn = 0; cyc();
    fadeInEn = 1; cyc();
    check(rampActive, "R8 ramp running", rampActive, 1);
    fadeOutEn = 1;
    cyc();
    check(!rampActive && !doneRef && !doneLimit, "R8 fade-out aborts",
          {rampActive, doneRef, doneLimit}, 0);

    // R11 start at or above reference
    fadeOutEn = 0; fadeInEn = 0; refLevel = 7'd50;
    loadGain(7'd60);
    fadeInEn = 1;
    cyc();
    check(doneRef && !rampActive, "R11 immediate done", {doneRef, rampActive}, 2);
    cyc();
    check(!doneRef && gainCode == 60, "R11 gain unchanged", gainCode, 60);

    summary();
  end

endmodule